// File: doc/BRIEF.md
# Edge/Level Interrupt Controller Bank

This block collects up to `BANKS*32` interrupt lines and drives two processor request outputs, one for the normal interrupt path (IRQ) and one for the fast path (FIQ). Each line has its own configuration word, which sets a 5-bit priority, a trigger mode and a path select. Input pins are active high. They pass through a two-flop synchroniser before trigger detection. An edge-triggered line becomes pending on a transition into the active state. A level-sensitive line stays pending for as long as its input is active.

Software uses a 32-bit word register interface with a one-cycle read latency. When an output path is armed and an eligible line is pending, the output asserts and the winning line number is latched as that path's vector code. The output then holds until software writes the matching re-arm bit in the control word. Reading a vector code acknowledges the latched line, but only when that line is edge-triggered. The bank index is taken from address bits [9:8]. Address bits [1:0] are ignored.

Top module: `edge_level_intc`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low and every pending bit is 0. Every mask bit is 1. Every line configuration word reads 0, which means priority 0, edge mode and IRQ path.
- R2: The configuration word of line L in bank B is at byte address B*0x100 + 0x1C + 4*L. Its fields are priority in bits [6:2], trigger mode in bit 1 (0 = edge, 1 = level) and FIQ select in bit 0. A read returns the same layout with all other bits 0.
- R3: An edge-mode line becomes pending only when its synchronised input goes from 0 to 1. An input held at 1 does not make the line pending again after it has been acknowledged.
- R4: A level-mode line is pending on every cycle its synchronised input is 1. A vector read does not clear it. A write to the pending register cannot clear it while the input is still 1.
- R5: A write to the pending register at bank offset 0x00 ANDs that bank's pending bits with the written word. A read of the same offset returns those pending bits.
- R6: The IRQ vector code is read at 0x010 and the FIQ vector code at 0x014. Each returns the latched global line index, which is 32*bank + line. If the latched line is edge-mode, the read clears its pending bit.
- R7: Among eligible lines, the lowest priority value wins. On a tie, the higher global line index wins.
- R8: A pending, unmasked line with FIQ select 1 can only drive `fiq_o` and the FIQ vector. A line with FIQ select 0 can only drive `irq_o` and the IRQ vector.
- R9: Once asserted, an output stays high until a write to the control word at 0x018 sets bit 0 (IRQ) or bit 1 (FIQ). That output is low in the following cycle. If an eligible line is still pending, the output asserts again one cycle later. Writing one path's bit does not affect the other path.
- R10: The mask register at bank offset 0x04 is read/write. A line whose mask bit is 1 never causes an output.
- R11: The bank is selected by address bits [9:8], and banks at or above `BANKS` are unmapped. The vector codes and the control word exist only at bank index 0.
- R12: Writes to unmapped offsets have no effect, and reads of them return 0. Unmapped offsets include 0x08, 0x0C, 0xA0 to 0xFC, and the vector and control offsets in non-zero banks. The vector codes are read-only.
- R13: A write to bank offset 0x9C sets the pending bit of every line whose data bit is 1. A read of this offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | BANKS*32 | Active-high interrupt input pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Byte address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en`, 0 otherwise |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted pending bit or a wrong trigger mode shows up at the ports in one of two ways. An output asserts when it should stay quiet, or a pending read differs, within a few cycles of the input or write that caused it. A wrong arbitration decision shows only in the vector code. It stays hidden until software reads that code, and it then persists until the path is re-armed. A faulty arm flag is silent until the next control write, after which the output fails to return or returns at the wrong cycle. For this reason the model is compared on every clock rather than only at directed reads.

// File: rtl/edge_level_intc.sv
module edge_level_intc #(
  parameter int BANKS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BANKS*32-1:0]   irq_in,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [9:0]            addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rd_data,
  output logic                  irq_o,
  output logic                  fiq_o
);
  localparam int NL = BANKS * 32;
  localparam int IW = (NL > 1) ? $clog2(NL) : 1;

  logic [NL-1:0] sync1, sync2, hist, pend, pend_nx, mask, lvl, fsel;
  logic [4:0]    prio [NL];
  logic [1:0]    armed, outq, has, ack;
  logic [1:0][IW-1:0] vec, win;

  logic [1:0] bsel;
  logic [7:0] off, ldiff;
  logic       bank_ok, glob, line_reg;
  int         bbase, gl;

  assign bsel     = addr[9:8];
  assign off      = {addr[7:2], 2'b00};
  assign bank_ok  = int'(bsel) < BANKS;
  assign glob     = bank_ok && (bsel == 2'd0);
  assign bbase    = bank_ok ? int'(bsel) * 32 : 0;
  assign ldiff    = off - 8'h1C;
  assign line_reg = bank_ok && (off >= 8'h1C) && (off <= 8'h98);
  assign gl       = bbase + int'(ldiff[6:2]);

  logic wr_pend, wr_mask, wr_ctrl, wr_sw, wr_lvl;
  assign wr_pend = wr_en && bank_ok && off == 8'h00;
  assign wr_mask = wr_en && bank_ok && off == 8'h04;
  assign wr_ctrl = wr_en && glob && off == 8'h18;
  assign wr_sw   = wr_en && bank_ok && off == 8'h9C;
  assign wr_lvl  = wr_en && line_reg;
  assign ack[0]  = rd_en && glob && off == 8'h10;
  assign ack[1]  = rd_en && glob && off == 8'h14;

  for (genvar f = 0; f < 2; f++) begin : g_arb
    logic [NL-1:0] cand;
    logic [IW-1:0] pick;
    logic [4:0]    best;
    assign cand = pend & ~mask & ((f == 1) ? fsel : ~fsel);
    always_comb begin
      pick = '0;
      best = 5'h1F;
      for (int i = 0; i < NL; i++)
        if (cand[i] && prio[i] <= best) begin
          best = prio[i];
          pick = IW'(i);
        end
    end
    assign has[f] = |cand;
    assign win[f] = pick;
  end

  logic [31:0] rdv;
  always_comb begin
    rdv = '0;
    if (bank_ok) begin
      if (off == 8'h00)      rdv = pend[bbase +: 32];
      else if (off == 8'h04) rdv = mask[bbase +: 32];
      else if (glob && off == 8'h10) rdv = 32'(vec[0]);
      else if (glob && off == 8'h14) rdv = 32'(vec[1]);
      else if (line_reg) rdv = {25'd0, prio[gl], lvl[gl], fsel[gl]};
    end
  end

  always_comb begin
    pend_nx = pend;
    if (wr_pend)
      pend_nx[bbase +: 32] = pend[bbase +: 32] & (wdata | (lvl[bbase +: 32] & sync2[bbase +: 32]));
    for (int f = 0; f < 2; f++)
      if (ack[f] && !lvl[vec[f]]) pend_nx[vec[f]] = 1'b0;
    if (wr_sw)
      pend_nx[bbase +: 32] = pend_nx[bbase +: 32] | wdata;
    pend_nx = pend_nx | (sync2 & (lvl | ~hist));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      hist    <= '0;
      pend    <= '0;
      mask    <= '1;
      lvl     <= '0;
      fsel    <= '0;
      for (int i = 0; i < NL; i++) prio[i] <= '0;
      armed   <= 2'b11;
      outq    <= 2'b00;
      vec     <= '0;
      rd_data <= '0;
    end else begin
      sync1   <= irq_in;
      sync2   <= sync1;
      hist    <= sync2;
      pend    <= pend_nx;
      rd_data <= rd_en ? rdv : 32'd0;
      if (wr_mask) mask[bbase +: 32] <= wdata;
      if (wr_lvl) begin
        prio[gl] <= wdata[6:2];
        lvl[gl]  <= wdata[1];
        fsel[gl] <= wdata[0];
      end
      for (int f = 0; f < 2; f++) begin
        if (wr_ctrl && wdata[f]) begin
          outq[f]  <= 1'b0;
          armed[f] <= 1'b1;
        end else if (armed[f] && has[f]) begin
          outq[f]  <= 1'b1;
          armed[f] <= 1'b0;
          vec[f]   <= win[f];
        end
      end
    end
  end

  assign irq_o = outq[0];
  assign fiq_o = outq[1];
endmodule

// File: rtl/edge_level_intc_chk.sv
module edge_level_intc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [9:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rd_data,
  input logic        irq_o,
  input logic        fiq_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && addr[9:2] == 8'h06;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_o && !fiq_o));

  a_r9_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(ctrl_wr && wdata[0])) |=> irq_o);

  a_r9_fiq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && !(ctrl_wr && wdata[1])) |=> fiq_o);

  a_r9_irq_rearm_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[0]) |=> !irq_o);

  a_r9_fiq_rearm_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[1]) |=> !fiq_o);

  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr[7:2] >= 6'h27 || addr[7:2] == 6'h02 || addr[7:2] == 6'h03)) |=> rd_data == 32'd0);
endmodule

bind edge_level_intc edge_level_intc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rd_data(rd_data), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/edge_level_intc_tb_top.sv
`timescale 1ns/1ps
module edge_level_intc_tb_top;
  localparam int NB = 2;
  localparam int NL = NB * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic irq_o, fiq_o;

  int n_checks = 0, n_fail = 0;
  logic [31:0] r;

  always #2.5 clk = ~clk;

  edge_level_intc #(.BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq_o(irq_o), .fiq_o(fiq_o));

  // behavioural reference model
  bit m_s1[NL], m_s2[NL], m_hist[NL], m_pend[NL], m_mask[NL], m_lvl[NL], m_fsel[NL];
  bit np[NL];
  int m_prio[NL];
  int m_vec[2];
  bit m_armed[2], m_out[2];
  logic [31:0] m_rd;
  int b, o, k, best, wsel;
  bit inb, g, any;
  logic [31:0] nrd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_hist[i] = 0; m_pend[i] = 0;
        m_mask[i] = 1; m_lvl[i] = 0; m_fsel[i] = 0; m_prio[i] = 0;
      end
      m_vec[0] = 0; m_vec[1] = 0;
      m_armed[0] = 1; m_armed[1] = 1; m_out[0] = 0; m_out[1] = 0;
      m_rd = 0;
    end else begin
      b = int'(addr[9:8]);
      o = int'(addr[7:2]) * 4;
      inb = b < NB;
      g = inb && b == 0;
      nrd = 0;
      if (rd_en && inb) begin
        if (o == 0) for (int i = 0; i < 32; i++) nrd[i] = m_pend[b*32+i];
        else if (o == 4) for (int i = 0; i < 32; i++) nrd[i] = m_mask[b*32+i];
        else if (g && o == 16) nrd = m_vec[0];
        else if (g && o == 20) nrd = m_vec[1];
        else if (o >= 28 && o <= 152) begin
          k = b*32 + (o - 28) / 4;
          nrd = m_prio[k] * 4 + m_lvl[k] * 2 + m_fsel[k];
        end
      end
      for (int i = 0; i < NL; i++) np[i] = m_pend[i];
      if (wr_en && inb && o == 0)
        for (int i = 0; i < 32; i++)
          if (!wdata[i] && !(m_lvl[b*32+i] && m_s2[b*32+i])) np[b*32+i] = 0;
      for (int f = 0; f < 2; f++)
        if (rd_en && g && o == 16 + 4*f && !m_lvl[m_vec[f]]) np[m_vec[f]] = 0;
      if (wr_en && inb && o == 156)
        for (int i = 0; i < 32; i++) if (wdata[i]) np[b*32+i] = 1;
      for (int i = 0; i < NL; i++)
        if (m_s2[i] && (m_lvl[i] || !m_hist[i])) np[i] = 1;
      for (int f = 0; f < 2; f++) begin
        any = 0; best = 99; wsel = 0;
        for (int i = NL - 1; i >= 0; i--)
          if (m_pend[i] && !m_mask[i] && (m_fsel[i] == (f == 1)) && m_prio[i] < best) begin
            best = m_prio[i]; wsel = i; any = 1;
          end
        if (wr_en && g && o == 24 && wdata[f]) begin
          m_out[f] = 0; m_armed[f] = 1;
        end else if (m_armed[f] && any) begin
          m_out[f] = 1; m_armed[f] = 0; m_vec[f] = wsel;
        end
      end
      if (wr_en && inb && o == 4) for (int i = 0; i < 32; i++) m_mask[b*32+i] = wdata[i];
      if (wr_en && inb && o >= 28 && o <= 152) begin
        k = b*32 + (o - 28) / 4;
        m_prio[k] = int'(wdata[6:2]); m_lvl[k] = wdata[1]; m_fsel[k] = wdata[0];
      end
      for (int i = 0; i < NL; i++) begin
        m_pend[i] = np[i];
        m_hist[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = irq_in[i];
      end
      m_rd = nrd;
    end
  end

  always @(negedge clk) if (rst_n) begin
    n_checks++;
    if (irq_o !== m_out[0] || fiq_o !== m_out[1] || rd_data !== m_rd) begin
      n_fail++;
      $display("FAIL model R6/R9 cycle: irq=%0b fiq=%0b rd=%h expected irq=%0b fiq=%0b rd=%h",
               irq_o, fiq_o, rd_data, m_out[0], m_out[1], m_rd);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    check("R1 irq_o", irq_o, 0);
    check("R1 fiq_o", fiq_o, 0);
    rd(10'h000, r); check("R1 pending", r, 0);
    rd(10'h004, r); check("R1 mask b0", r, 32'hFFFF_FFFF);
    rd(10'h104, r); check("R1 mask b1", r, 32'hFFFF_FFFF);
    rd(10'h01C, r); check("R1 line0 cfg", r, 0);
    // R2 layout
    wr(10'h030, 32'hFFFF_FFFF); rd(10'h030, r); check("R2 cfg readback", r, 32'h7F);
    wr(10'h030, 32'h0C); rd(10'h030, r); check("R2 cfg prio3 edge", r, 32'h0C);
    // R10 masked line stays quiet, R3 pending set
    irq_in[5] = 1; idle(6);
    check("R10 masked no irq", irq_o, 0);
    rd(10'h000, r); check("R3 edge pending", r, 32'h20);
    wr(10'h004, 0); idle(3);
    check("R10 unmasked irq", irq_o, 1);
    rd(10'h010, r); check("R6 irq vector", r, 5);
    rd(10'h000, r); check("R6 edge acked", r, 0);
    idle(5); rd(10'h000, r); check("R3 held input no retrigger", r, 0);
    wr(10'h018, 1); idle(3); check("R9 rearm nothing pending", irq_o, 0);
    irq_in[5] = 0; idle(3); irq_in[5] = 1; idle(6);
    check("R3 new edge", irq_o, 1);
    rd(10'h010, r); check("R3 vector", r, 5);
    irq_in[5] = 0; wr(10'h018, 1);
    // R4 level line 9
    wr(10'h040, 32'h0A); irq_in[9] = 1; idle(6);
    check("R4 level irq", irq_o, 1);
    rd(10'h010, r); check("R4 vector", r, 9);
    rd(10'h000, r); check("R4 vector read keeps level", r, 32'h200);
    wr(10'h000, 0); rd(10'h000, r); check("R4 clear write blocked", r, 32'h200);
    // R9 timing and independence
    wr(10'h018, 2); check("R9 fiq bit leaves irq", irq_o, 1);
    wr(10'h018, 1); check("R9 drop after rearm", irq_o, 0);
    idle(1); check("R9 reassert", irq_o, 1);
    irq_in[9] = 0; idle(4); wr(10'h000, 0);
    rd(10'h000, r); check("R5 clear after input low", r, 0);
    wr(10'h018, 1); idle(3); check("R9 quiet", irq_o, 0);
    // R13 software set, R5 AND, R7 lower value wins
    wr(10'h03C, 32'h00);
    wr(10'h09C, 32'h300); idle(3);
    rd(10'h000, r); check("R13 soft set", r, 32'h300);
    rd(10'h09C, r); check("R13 reads zero", r, 0);
    wr(10'h000, 32'h100); rd(10'h000, r); check("R5 and mask", r, 32'h100);
    rd(10'h010, r); check("R7 lowest value", r, 8);
    wr(10'h000, 0); wr(10'h018, 1);
    // R7 tie
    wr(10'h028, 32'h08); wr(10'h038, 32'h08); wr(10'h06C, 32'h10);
    wr(10'h09C, 32'h0010_0088); idle(3);
    rd(10'h010, r); check("R7 tie higher index", r, 7);
    wr(10'h000, 0); wr(10'h018, 1); idle(2);
    // R8 fiq path
    wr(10'h04C, 32'h01); wr(10'h09C, 32'h1000); idle(3);
    check("R8 fiq asserted", fiq_o, 1);
    check("R8 irq quiet", irq_o, 0);
    rd(10'h014, r); check("R8 fiq vector", r, 12);
    rd(10'h000, r); check("R6 fiq ack", r, 0);
    wr(10'h018, 2); idle(2); check("R9 fiq dropped", fiq_o, 0);
    // R11 bank 1
    wr(10'h104, 0); wr(10'h13C, 32'h04);
    irq_in[40] = 1; idle(6);
    check("R11 bank1 irq", irq_o, 1);
    rd(10'h110, r); check("R11 no vector in bank1", r, 0);
    rd(10'h010, r); check("R11 global index", r, 40);
    rd(10'h100, r); check("R11 bank1 pending acked", r, 0);
    rd(10'h13C, r); check("R11 bank1 cfg", r, 32'h04);
    irq_in[40] = 0; wr(10'h018, 1);
    // R12 unmapped
    wr(10'h0A0, 32'hFFFF_FFFF); rd(10'h0A0, r); check("R12 unmapped read", r, 0);
    wr(10'h008, 32'hFFFF_FFFF); rd(10'h004, r); check("R12 mask untouched", r, 0);
    wr(10'h010, 32'h3); rd(10'h010, r); check("R12 vector read-only", r, 40);
    wr(10'h304, 32'hFFFF_FFFF); rd(10'h304, r); check("R12 absent bank", r, 0);
    rd(10'h004, r); check("R12 absent bank write", r, 0);
    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule